// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel. A one-cycle count enable (`tick`) is its input clock, `gate` is its trigger or enable pin, and `out` is the waveform it produces. Software controls it through a small byte-wide register port. A write with `wr_ctl` high is a control word, and a write with `wr_ctl` low delivers a count byte. The current count or a frozen snapshot of it is available on `rd_data` at all times, and a `rd_en` pulse steps to the next byte.

The control word picks one of seven output functions and chooses binary or decimal (BCD) counting. It can also carry a latch command, which takes a snapshot of the count while counting goes on. The seven functions are an interrupt flag at terminal count, a retriggerable one-shot, a divide-by-N pulse train, a square wave, a strobe started by software, a strobe started by the gate pin, and gated event counting. The initial count N is written as two bytes.

Top module: `interval_timer`

## Requirements
- R1: After reset, `out` is low, the function is the terminal-count flag, and `rd_data` reads 0x00.
- R2: A control word with bit 7 clear sets the function from bits [2:0] and the count style from bit 3 (1 = BCD). The codes are 0 terminal-count flag, 1 one-shot, 2 rate pulse, 3 square wave, 4 software strobe, 5 gate strobe, and 6 or 7 event counting. A control word resets both byte pointers and drives `out` low for codes 0 and 6, and high for every other code.
- R3: A count write takes the low byte first and the high byte second. In every function except 1 and 5, the first tick after the high byte loads N into the counter. Each later tick lowers the counter by one, and the counter never changes in a cycle without a tick.
- R4: In BCD style the counter steps through decimal digits and wraps from 0000 to 9999. In binary style it wraps from 0000 to FFFF.
- R5: In function 0, `out` rises on the N-th tick after the load tick. It then stays high until the next control word or count write.
- R6: In function 1, a rising edge on `gate` or a high-byte count write arms a load on the next tick, and that load drives `out` low. `out` returns high N ticks later. A new gate edge while the one-shot is running reloads N.
- R7: In function 2 with N ≥ 2, `out` is low for exactly one tick period and repeats every N ticks. The low period is the (N-1)-th tick of each period counted from the load tick.
- R8: In function 3 with N ≥ 2, `out` is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high at the load tick. This holds in both count styles.
- R9: In function 4, `out` goes low for one tick period on the N-th tick after the load tick. It does this once per count write and is high at all other times.
- R10: In function 5, a rising gate edge arms a load on the next tick, and `out` pulses low for one tick period N ticks after that load. A new edge restarts the count. Writing the count alone does not start it, and gate edges have no effect in functions 0, 2, 3 and 4.
- R11: In function 6, the counter loads on the first tick after the high byte. After that it lowers only on ticks while `gate` is high, and `out` rises when it reaches zero.
- R12: Without a snapshot, `rd_data` shows the live count's low byte and then its high byte, and each `rd_en` pulse moves to the other byte.
- R13: A control word with bit 7 set is a latch command. It freezes the count as it stood before that cycle's tick and leaves the function unchanged. Reads then return the snapshot, low byte then high byte, while counting continues. Further latch commands are ignored until both bytes have been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable, the timer's input clock |
| gate | input | 1 | Trigger edge or counting window |
| wr_en | input | 1 | Register write strobe |
| wr_ctl | input | 1 | 1 = control word, 0 = count byte |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, steps the byte pointer |
| rd_data | output | 8 | Selected byte of the count or snapshot |
| out | output | 1 | Timer output waveform |

## Verification
The two functions that can share a cycle are a latch command and a counting tick. The bench provokes this by raising `wr_en` with a latch control word and `tick` on the same clock edge, deep into a long rate-generator count. It expects the snapshot to hold the count from before that edge and the live readout to show the decrement. It then ticks three more times and issues a second latch command. The snapshot must keep the first value, and the live count must reflect all four ticks.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

    typedef enum logic [2:0] {
        FN_TCFLAG  = 3'd0,
        FN_ONESHOT = 3'd1,
        FN_RATE    = 3'd2,
        FN_SQUARE  = 3'd3,
        FN_SWSTB   = 3'd4,
        FN_HWSTB   = 3'd5,
        FN_EVENT   = 3'd6
    } fn_e;

    localparam int CW_BCD_BIT   = 3;
    localparam int CW_LATCH_BIT = 7;

endpackage

// File: rtl/it_decrement.sv
module it_decrement #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] nxt
);
    localparam int DIGITS = W / 4;

    logic [W-1:0]      bcd_nxt;
    logic [DIGITS-1:0] borrow;

    assign borrow[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] d;
        assign d = val[4*i +: 4];
        assign bcd_nxt[4*i +: 4] = !borrow[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
        if (i < DIGITS - 1) begin : g_borrow
            assign borrow[i+1] = borrow[i] && (d == 4'd0);
        end
    end

    assign nxt = bcd ? bcd_nxt : val - 1'b1;

    function automatic logic is_bcd(input logic [W-1:0] v);
        is_bcd = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (v[4*i +: 4] > 4'd9) is_bcd = 1'b0;
        end
    endfunction

    always_comb begin
        if (bcd && is_bcd(val)) begin
            // R4
            dec_bcd_valid_chk: assert (is_bcd(nxt));
        end
    end
endmodule

// File: rtl/it_halve.sv
module it_halve #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] half
);
    localparam int DIGITS = W / 4;

    logic [W-1:0] bcd_half;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        if (i == DIGITS - 1) begin : g_top
            assign bcd_half[4*i +: 4] = {1'b0, val[4*i+1 +: 3]};
        end else begin : g_low
            assign bcd_half[4*i +: 4] = {1'b0, val[4*i+1 +: 3]} + (val[4*i+4] ? 4'd5 : 4'd0);
        end
    end

    assign half = bcd ? bcd_half : (val >> 1);
endmodule

// File: rtl/it_readback.sv
module it_readback #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         latch_cmd,
    input  logic         clr,
    input  logic         rd_en,
    output logic [7:0]   rd_data
);
    localparam int BYTES = W / 8;
    localparam int PW    = (BYTES > 1) ? $clog2(BYTES) : 1;

    typedef struct packed {
        logic          latched;
        logic [W-1:0]  snap;
        logic [PW-1:0] ptr;
    } rb_t;

    rb_t rb_d, rb_q;
    logic [W-1:0] src;

    always_comb begin
        rb_d = rb_q;
        if (clr) begin
            rb_d.latched = 1'b0;
            rb_d.ptr     = '0;
        end else if (latch_cmd) begin
            if (!rb_q.latched) begin
                rb_d.latched = 1'b1;
                rb_d.snap    = cnt;
                rb_d.ptr     = '0;
            end
        end else if (rd_en) begin
            if (rb_q.ptr == PW'(BYTES - 1)) begin
                rb_d.ptr     = '0;
                rb_d.latched = 1'b0;
            end else begin
                rb_d.ptr = rb_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign src     = rb_q.latched ? rb_q.snap : cnt;
    assign rd_data = src[8*rb_q.ptr +: 8];

    // R13
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.latched && !clr) |=> $stable(rb_q.snap));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import interval_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       gate,
    input  logic       wr_en,
    input  logic       wr_ctl,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       out
);
    localparam int LOW_W = W - 8;

    typedef struct packed {
        fn_e            fn;
        logic           bcd;
        logic           out;
        logic           armed;
        logic           pend;
        logic           wptr;
        logic           gate_q;
        logic [LOW_W-1:0] lsb;
        logic [W-1:0]   reload;
        logic [W-1:0]   half;
        logic [W-1:0]   cnt;
    } st_t;

    st_t s_d, s_q;

    logic [W-1:0] dec_val, half_val, new_n;
    logic ctl_wr, cnt_wr, latch_cmd, mode_wr, gate_rise;
    logic trig_fn, strobe_fn, periodic_fn, low_start_fn;
    fn_e  new_fn;

    assign ctl_wr    = wr_en && wr_ctl;
    assign cnt_wr    = wr_en && !wr_ctl;
    assign latch_cmd = ctl_wr && wr_data[CW_LATCH_BIT];
    assign mode_wr   = ctl_wr && !wr_data[CW_LATCH_BIT];
    assign gate_rise = gate && !s_q.gate_q;
    assign new_n     = {wr_data, s_q.lsb};
    assign new_fn    = (wr_data[2:0] == 3'd7) ? FN_EVENT : fn_e'(wr_data[2:0]);

    assign trig_fn      = (s_q.fn == FN_ONESHOT) || (s_q.fn == FN_HWSTB);
    assign strobe_fn    = (s_q.fn == FN_SWSTB) || (s_q.fn == FN_HWSTB);
    assign periodic_fn  = (s_q.fn == FN_RATE) || (s_q.fn == FN_SQUARE);
    assign low_start_fn = (s_q.fn == FN_TCFLAG) || (s_q.fn == FN_EVENT);

    it_decrement #(.W(W)) u_dec (.val(s_q.cnt), .bcd(s_q.bcd), .nxt(dec_val));
    it_halve     #(.W(W)) u_half (.val(new_n), .bcd(s_q.bcd), .half(half_val));

    always_comb begin
        s_d        = s_q;
        s_d.gate_q = gate;

        if (tick) begin
            if (s_q.pend) begin
                s_d.pend  = 1'b0;
                s_d.armed = 1'b1;
                s_d.cnt   = s_q.reload;
                s_d.out   = !(low_start_fn || s_q.fn == FN_ONESHOT);
            end else if (periodic_fn && s_q.armed) begin
                if (s_q.cnt == W'(1)) begin
                    s_d.cnt = s_q.reload;
                    s_d.out = 1'b1;
                end else begin
                    s_d.cnt = dec_val;
                    if (s_q.fn == FN_RATE && dec_val == W'(1)) s_d.out = 1'b0;
                    if (s_q.fn == FN_SQUARE && dec_val == s_q.half) s_d.out = 1'b0;
                end
            end else if (s_q.fn != FN_EVENT || gate) begin
                s_d.cnt = dec_val;
                if (strobe_fn && !s_q.out) s_d.out = 1'b1;
                if (s_q.armed && dec_val == '0) begin
                    s_d.armed = 1'b0;
                    s_d.out   = !strobe_fn;
                end
            end
        end

        if (cnt_wr) begin
            if (!s_q.wptr) begin
                s_d.lsb  = wr_data;
                s_d.wptr = 1'b1;
            end else begin
                s_d.reload = new_n;
                s_d.half   = half_val;
                s_d.wptr   = 1'b0;
                if (s_q.fn != FN_HWSTB) s_d.pend = 1'b1;
                if (low_start_fn) begin
                    s_d.out   = 1'b0;
                    s_d.armed = 1'b0;
                end
            end
        end

        if (trig_fn && gate_rise) s_d.pend = 1'b1;

        if (mode_wr) begin
            s_d.fn    = new_fn;
            s_d.bcd   = wr_data[CW_BCD_BIT];
            s_d.out   = !(new_fn == FN_TCFLAG || new_fn == FN_EVENT);
            s_d.armed = 1'b0;
            s_d.pend  = 1'b0;
            s_d.wptr  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    it_readback #(.W(W)) u_rb (
        .clk(clk), .rst_n(rst_n), .cnt(s_q.cnt), .latch_cmd(latch_cmd),
        .clr(mode_wr), .rd_en(rd_en), .rd_data(rd_data)
    );

    assign out = s_q.out;

    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cnt));

    // R5
    tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fn == FN_TCFLAG && s_q.out && !cnt_wr && !mode_wr) |=> s_q.out);

    // R7
    rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fn == FN_RATE && !s_q.out && tick && !mode_wr) |=> s_q.out);

    // R9 R10
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_fn && !s_q.out && tick && !mode_wr) |=> s_q.out);
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, gate = 1'b0, wr_en = 1'b0, wr_ctl = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic out;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    interval_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .wr_en(wr_en),
        .wr_ctl(wr_ctl), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .out(out)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic ctl, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_ctl = ctl; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m, input logic bcd);
        wr(1'b1, {4'b0000, bcd, m});
    endtask

    task automatic load(input logic [15:0] n);
        wr(1'b0, n[7:0]);
        wr(1'b0, n[15:8]);
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic set_gate(input logic v);
        @(negedge clk); gate = v;
        @(negedge clk);
    endtask

    task automatic rd_count(output logic [15:0] v);
        @(negedge clk); v[7:0] = rd_data; rd_en = 1'b1;
        @(negedge clk); v[15:8] = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic exp_rate(input int k, input int n);
        return !(k >= 1 && (k % n) == n - 1);
    endfunction

    function automatic logic exp_square(input int k, input int n);
        return (k % n) < (n + 1) / 2;
    endfunction

    function automatic logic [15:0] bcd_minus1(input logic [15:0] v);
        int n;
        n = v[15:12] * 1000 + v[11:8] * 100 + v[7:4] * 10 + v[3:0];
        n = (n + 9999) % 10000;
        return {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
    endfunction

    function automatic int bcd_to_int(input logic [15:0] v);
        return v[15:12] * 1000 + v[11:8] * 100 + v[7:4] * 10 + v[3:0];
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        int unsigned seed;
        seed = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out after reset", out, 0);
        check("R1", "rd_data after reset", rd_data, 0);

        // R2 R3 R5 R12: terminal-count flag, binary
        n = $urandom_range(3, 20);
        set_mode(3'd0, 1'b0);
        check("R2", "fn0 initial out", out, 0);
        load(16'(n));
        do_tick();
        rd_count(v);
        check("R3", "count at load", v, n);
        for (int k = 1; k <= n + 2; k++) begin
            do_tick();
            if (k == 2) begin
                rd_count(v);
                check("R12", "live count", v, n - 2);
            end
            check("R5", $sformatf("fn0 out tick %0d", k), out, (k >= n));
        end

        // R4: decimal borrow and wrap, binary wrap
        set_mode(3'd0, 1'b1);
        load(16'h0100);
        do_tick(); do_tick();
        rd_count(v);
        check("R4", "bcd borrow", v, 16'h0099);
        load(16'h0002);
        repeat (4) do_tick();
        rd_count(v);
        check("R4", "bcd wrap", v, 16'h9999);
        for (int i = 0; i < 5; i++) begin
            logic [15:0] b;
            b = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)),
                 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            load(b);
            do_tick(); do_tick();
            rd_count(v);
            check("R4", "bcd random step", v, bcd_minus1(b));
        end
        set_mode(3'd0, 1'b0);
        load(16'h0001);
        repeat (3) do_tick();
        rd_count(v);
        check("R4", "binary wrap", v, 16'hFFFF);

        // R7: rate generator
        n = $urandom_range(2, 9);
        set_mode(3'd2, 1'b0);
        check("R2", "fn2 initial out", out, 1);
        load(16'(n));
        do_tick();
        for (int k = 1; k <= 3 * n; k++) begin
            do_tick();
            check("R7", $sformatf("rate N=%0d tick %0d", n, k), out, exp_rate(k, n));
        end

        // R8: square wave, odd, random, and BCD count
        for (int pass = 0; pass < 3; pass++) begin
            logic [15:0] w;
            w = (pass == 0) ? 16'd7 : (pass == 1) ? 16'($urandom_range(2, 11)) : 16'h0015;
            n = (pass == 2) ? bcd_to_int(w) : int'(w);
            set_mode(3'd3, pass == 2);
            load(w);
            do_tick();
            check("R8", "square at load", out, 1);
            for (int k = 1; k <= 2 * n; k++) begin
                do_tick();
                check("R8", $sformatf("square N=%0d tick %0d", n, k), out, exp_square(k, n));
            end
        end

        // R9 R10: software strobe, gate edges ignored
        n = $urandom_range(2, 10);
        set_mode(3'd4, 1'b0);
        load(16'(n));
        do_tick();
        for (int k = 1; k <= n + 3; k++) begin
            set_gate(1'($urandom_range(0, 1)));
            do_tick();
            check("R9", $sformatf("sw strobe tick %0d", k), out, (k != n));
        end

        // R6: one-shot, software and gate triggers, retrigger
        set_mode(3'd1, 1'b0);
        check("R2", "fn1 initial out", out, 1);
        set_gate(1'b0);
        load(16'd6);
        do_tick();
        check("R6", "sw trigger low", out, 0);
        for (int k = 1; k <= 6; k++) begin
            do_tick();
            check("R6", $sformatf("one-shot tick %0d", k), out, (k >= 6));
        end
        set_gate(1'b1);
        do_tick();
        check("R6", "gate trigger low", out, 0);
        repeat (3) do_tick();
        set_gate(1'b0); set_gate(1'b1);
        do_tick();
        for (int k = 1; k <= 6; k++) begin
            do_tick();
            check("R6", $sformatf("retrigger tick %0d", k), out, (k >= 6));
        end

        // R10: gate strobe
        set_mode(3'd5, 1'b0);
        load(16'd4);
        for (int k = 1; k <= 5; k++) begin
            do_tick();
            check("R10", "no trigger, no strobe", out, 1);
        end
        set_gate(1'b0); set_gate(1'b1);
        do_tick();
        do_tick(); do_tick();
        set_gate(1'b0); set_gate(1'b1);
        do_tick();
        for (int k = 1; k <= 6; k++) begin
            do_tick();
            check("R10", $sformatf("hw strobe tick %0d", k), out, (k != 4));
        end

        // R11: event counting
        set_mode(3'd6, 1'b0);
        check("R2", "fn6 initial out", out, 0);
        set_gate(1'b0);
        load(16'd3);
        do_tick(); do_tick(); do_tick();
        rd_count(v);
        check("R11", "held while gate low", v, 3);
        set_gate(1'b1);
        for (int k = 1; k <= 4; k++) begin
            do_tick();
            check("R11", $sformatf("event tick %0d", k), out, (k >= 3));
        end

        // R13: latch with same-cycle tick, second latch ignored
        set_mode(3'd2, 1'b0);
        load(16'd1000);
        do_tick();
        repeat (5) do_tick();
        @(negedge clk); wr_en = 1'b1; wr_ctl = 1'b1; wr_data = 8'h80; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        repeat (3) do_tick();
        wr(1'b1, 8'h80);
        rd_count(v);
        check("R13", "snapshot before tick", v, 995);
        rd_count(v);
        check("R13", "live count after snapshot", v, 991);
        check("R13", "function unchanged", out, 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule